// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO

This block forms one wide FIFO out of several FIFO slices of equal depth placed side by side. Every slice takes the same write clock, write enable, read clock, read enable and master reset. The wide write word is split across the slices and the wide read word is rebuilt from them, with slice 0 holding the least significant bits. Each slice is a dual-clock FIFO. It crosses clock domains with Gray-coded pointers and two-flop synchronizers.

Skew between the two clocks can make one slice report data or space a cycle earlier than another. A single merge stage therefore combines the per-slice status into one read-side flag and one write-side flag. These flags always follow the most pessimistic slice. The block accepts a read or a write only when the matching composite flag allows it.

Two behaviours are available, and the block samples the choice while master reset is held low. In standard mode a read presents its word on the next read clock edge, and the flags are active-low empty and full. In fall-through mode the head word reaches the output without any read, and the flags are active-low output-ready and input-ready. The half-full indication comes from slice 0.

Top module: `wxf_top`

## Requirements
- R1: The read word is the concatenation of the slice outputs, with slice 0 in the least significant SLICE_W bits. The total width is NUM_SLICES*SLICE_W, and each slice carries its own part of the written word unaltered.
- R2: On each clock edge while mrst_n is low, the block samples fwft_sel (0 = standard, 1 = fall-through). Changes to fwft_sel after reset is released have no effect until the next master reset.
- R3: In standard mode, rflag_n is 0 (empty) whenever any slice is empty, and wflag_n is 0 (full) whenever any slice is full. After reset, rflag_n = 0 and wflag_n = 1.
- R4: In standard mode, an accepted read puts the head word on rd_data after that read clock edge. rd_data then holds its value until the next accepted read.
- R5: In fall-through mode, the head word appears on rd_data with no read. rflag_n is 0 (ready) only when every slice has a word at its output, and wflag_n is 0 (ready) only when every slice has space. After reset, rflag_n = 1 and wflag_n = 0.
- R6: A write is accepted only when wflag_n shows space. A write attempted while the composite flag shows no space changes neither the stored data nor the flags.
- R7: A read is accepted only when rflag_n shows data. A read attempted while the FIFO is empty leaves rd_data unchanged and does not move the read position.
- R8: With the read and write clocks at unrelated frequencies, words leave the FIFO in the order they were written, in both modes.
- R9: half_full is 1 when the number of words written into slice 0's storage and not yet taken out is at least 2**ADDR_W/2, and 0 otherwise.
- R10: In standard mode the FIFO holds 2**ADDR_W words before it reports full. In fall-through mode it holds 2**ADDR_W+1 words, because the output register counts as a storage place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous; mode is sampled while low |
| fwft_sel | input | 1 | Mode choice: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | NUM_SLICES*SLICE_W | Write word, slice 0 in the low bits |
| wflag_n | output | 1 | Composite full (standard) or input-ready (fall-through), active low |
| half_full | output | 1 | Half-full indication from slice 0, write domain |
| rd_en | input | 1 | Read request |
| rd_data | output | NUM_SLICES*SLICE_W | Read word, slice 0 in the low bits |
| rflag_n | output | 1 | Composite empty (standard) or output-ready (fall-through), active low |

## Verification
The bench checks the capacity edge in both modes. A design that counted the fall-through output register wrongly would report full one word early or late, and a design without write gating would overwrite the oldest word; both faults show up when the stored words are drained and compared. Reads while empty and writes while full are driven directly against the flags. An ungated pointer would then return a stale or duplicate word. The bench also toggles the mode pin after reset, where a design that did not latch the mode would start falling words through in standard mode. Long streams with unrelated clock rates and irregular pauses then compare every wide word. This exposes slice swaps, lost ordering, and flags that release a read before the slowest slice is ready.

// File: rtl/wxf_pkg.sv
package wxf_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } wxf_mode_e;

   // Gray to binary conversion on a 32-bit container; callers zero-extend.
   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/wxf_sync.sv
module wxf_sync #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/wxf_slice.sv
module wxf_slice
   import wxf_pkg::*;
#(
   parameter int W  = 8,
   parameter int AW = 3
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         rst_n,
   input  logic         fwft,
   input  logic         wr_i,
   input  logic [W-1:0] din,
   input  logic         rd_i,
   output logic [W-1:0] dout,
   output logic         full_o,
   output logic         empty_o,
   output logic         ovalid_o,
   output logic         half_o
);
   localparam int DEPTH = 1 << AW;
   localparam int PW    = AW + 1;

   logic [W-1:0]  mem [DEPTH];

   // write domain
   logic [PW-1:0] wbin, wgray, wbin_nx;
   logic [PW-1:0] rgray_w, rbin_w, used;
   logic [31:0]   rbin_w32;

   // read domain
   logic [PW-1:0] rbin, rgray, rbin_nx;
   logic [PW-1:0] wgray_r;
   logic          ram_empty, fetch, ovalid;
   logic [W-1:0]  dq;

   assign wbin_nx = wbin + PW'(1);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_i) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_i) mem[wbin[AW-1:0]] <= din;
   end

   wxf_sync #(.W(PW)) u_r2w (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_w)
   );

   assign full_o   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
   assign rbin_w32 = gray2bin(32'(rgray_w));
   assign rbin_w   = rbin_w32[PW-1:0];
   assign used     = wbin - rbin_w;
   assign half_o   = (used >= PW'(DEPTH / 2));

   wxf_sync #(.W(PW)) u_w2r (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_r)
   );

   assign ram_empty = (rgray == wgray_r);
   assign rbin_nx   = rbin + PW'(1);

   generate
      always_comb begin
         if (fwft) fetch = !ram_empty && (!ovalid || rd_i);
         else      fetch = rd_i && !ram_empty;
      end
   endgenerate

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         dq     <= '0;
         ovalid <= 1'b0;
      end else begin
         if (fetch) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            dq    <= mem[rbin[AW-1:0]];
         end
         if (fwft) ovalid <= fetch || (ovalid && !rd_i);
         else      ovalid <= 1'b0;
      end
   end

   assign dout     = dq;
   assign empty_o  = ram_empty;
   assign ovalid_o = ovalid;

   // R6
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      wr_i |-> !full_o);

   // R7
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      rd_i |-> (fwft ? ovalid : !ram_empty));
endmodule

// File: rtl/wxf_flagmerge.sv
module wxf_flagmerge
   import wxf_pkg::*;
#(
   parameter int N = 2
) (
   input  wxf_mode_e      wmode,
   input  wxf_mode_e      rmode,
   input  logic [N-1:0]   full_v,
   input  logic [N-1:0]   empty_v,
   input  logic [N-1:0]   ovalid_v,
   input  logic           wr_en,
   input  logic           rd_en,
   output logic           wflag_n,
   output logic           rflag_n,
   output logic           wr_go,
   output logic           rd_go
);
   logic [N-1:0] ff_n, ef_n, ir_n, or_n;

   assign ff_n = ~full_v;
   assign ef_n = ~empty_v;
   assign ir_n = full_v;
   assign or_n = ~ovalid_v;

   always_comb begin
      if (wmode == MODE_FWFT) begin
         wflag_n = |ir_n;
         wr_go   = wr_en && !wflag_n;
      end else begin
         wflag_n = &ff_n;
         wr_go   = wr_en && wflag_n;
      end
      if (rmode == MODE_FWFT) begin
         rflag_n = |or_n;
         rd_go   = rd_en && !rflag_n;
      end else begin
         rflag_n = &ef_n;
         rd_go   = rd_en && rflag_n;
      end
   end
endmodule

// File: rtl/wxf_top.sv
module wxf_top
   import wxf_pkg::*;
#(
   parameter int NUM_SLICES = 2,
   parameter int SLICE_W    = 8,
   parameter int ADDR_W     = 3,
   localparam int TOTAL_W   = NUM_SLICES * SLICE_W
) (
   input  logic               wclk,
   input  logic               rclk,
   input  logic               mrst_n,
   input  logic               fwft_sel,
   input  logic               wr_en,
   input  logic [TOTAL_W-1:0] wr_data,
   output logic               wflag_n,
   output logic               half_full,
   input  logic               rd_en,
   output logic [TOTAL_W-1:0] rd_data,
   output logic               rflag_n
);
   generate
      if (NUM_SLICES < 1) begin : g_bad_slices
         $error("wxf_top: NUM_SLICES must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wxf_top: ADDR_W must be at least 2");
      end
      if (SLICE_W < 1) begin : g_bad_width
         $error("wxf_top: SLICE_W must be at least 1");
      end
   endgenerate

   wxf_mode_e wmode, rmode;

   // mode captured on each domain's clock while master reset is held
   always_ff @(posedge wclk) begin
      if (!mrst_n) wmode <= wxf_mode_e'(fwft_sel);
   end

   always_ff @(posedge rclk) begin
      if (!mrst_n) rmode <= wxf_mode_e'(fwft_sel);
   end

   logic [NUM_SLICES-1:0] full_v, empty_v, ovalid_v, half_v;
   logic                  wr_go, rd_go;

   wxf_flagmerge #(.N(NUM_SLICES)) u_merge (
      .wmode    (wmode),
      .rmode    (rmode),
      .full_v   (full_v),
      .empty_v  (empty_v),
      .ovalid_v (ovalid_v),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wflag_n  (wflag_n),
      .rflag_n  (rflag_n),
      .wr_go    (wr_go),
      .rd_go    (rd_go)
   );

   genvar s;
   generate
      for (s = 0; s < NUM_SLICES; s++) begin : g_slice
         wxf_slice #(.W(SLICE_W), .AW(ADDR_W)) u_slice (
            .wclk     (wclk),
            .rclk     (rclk),
            .rst_n    (mrst_n),
            .fwft     (rmode == MODE_FWFT),
            .wr_i     (wr_go),
            .din      (wr_data[s*SLICE_W +: SLICE_W]),
            .rd_i     (rd_go),
            .dout     (rd_data[s*SLICE_W +: SLICE_W]),
            .full_o   (full_v[s]),
            .empty_o  (empty_v[s]),
            .ovalid_o (ovalid_v[s]),
            .half_o   (half_v[s])
         );

         if (s > 0) begin : g_agree
            // R9
            hf_agree_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
               half_v[s] == half_v[0]);
         end
      end
   endgenerate

   assign half_full = half_v[0];

   // R4
   rd_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
      (rmode == MODE_STD && !rd_go) |=> $stable(rd_data));
endmodule

// File: tb/wxf_top_test.sv
`timescale 1ns/100ps
module wxf_top_test;
   localparam int TW = 16;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          mrst_n = 1'b0, fwft_sel = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [TW-1:0] wr_data = '0;
   logic [TW-1:0] rd_data;
   logic          wflag_n, rflag_n, half_full;

   int  nchk = 0, nbad = 0;
   bit  fm   = 1'b0;
   bit  done = 1'b0;

   always #5    wclk = ~wclk;
   always #6.5  rclk = ~rclk;

   wxf_top uut (
      .wclk      (wclk),
      .rclk      (rclk),
      .mrst_n    (mrst_n),
      .fwft_sel  (fwft_sel),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wflag_n   (wflag_n),
      .half_full (half_full),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .rflag_n   (rflag_n)
   );

   function automatic logic [TW-1:0] w(input int i);
      logic [7:0] hi, lo;
      hi = 8'(i * 37 + 5);
      lo = 8'(i) ^ 8'hA5;
      return {hi, lo};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wwait(input int n);
      repeat (n) @(negedge wclk);
   endtask

   task automatic rwait(input int n);
      repeat (n) @(negedge rclk);
   endtask

   task automatic do_reset(input bit mode);
      fm       = mode;
      mrst_n   = 1'b0;
      fwft_sel = mode;
      wr_en    = 1'b0;
      rd_en    = 1'b0;
      wwait(4);
      rwait(4);
      mrst_n = 1'b1;
      wwait(3);
      rwait(3);
   endtask

   function automatic bit has_space();
      return fm ? (wflag_n == 1'b0) : (wflag_n == 1'b1);
   endfunction

   function automatic bit has_data();
      return fm ? (rflag_n == 1'b0) : (rflag_n == 1'b1);
   endfunction

   task automatic push(input logic [TW-1:0] d);
      @(negedge wclk);
      while (!has_space()) @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic raw_write(input logic [TW-1:0] d);
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic raw_read();
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
   endtask

   task automatic pop(input string tag, input logic [TW-1:0] exp);
      @(negedge rclk);
      while (!has_data()) @(negedge rclk);
      if (fm) begin
         chk(tag, 32'(rd_data), 32'(exp));
         rd_en = 1'b1;
         @(negedge rclk);
         rd_en = 1'b0;
      end else begin
         rd_en = 1'b1;
         @(negedge rclk);
         rd_en = 1'b0;
         chk(tag, 32'(rd_data), 32'(exp));
      end
   endtask

   task automatic stream(input int base, input int n);
      fork
         begin
            for (int i = 0; i < n; i++) begin
               push(w(base + i));
               if (i % 5 == 3) wwait(3);
               if (i % 23 == 11) wwait(17);
            end
         end
         begin
            for (int i = 0; i < n; i++) begin
               pop("R8 stream order", w(base + i));
               if (i % 7 == 2) rwait(4);
               if (i % 31 == 5) rwait(20);
            end
         end
      join
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
         $finish;
      end
   endtask

   initial begin
      #1500000;
      nchk++;
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // ---------------- standard mode ----------------
      do_reset(1'b0);
      chk("R3 reset empty flag", 32'(rflag_n), 32'd0);
      chk("R3 reset full flag", 32'(wflag_n), 32'd1);
      chk("R9 reset half_full", 32'(half_full), 32'd0);

      raw_read();
      chk("R7 read on empty keeps data", 32'(rd_data), 32'd0);
      chk("R7 still empty", 32'(rflag_n), 32'd0);

      fwft_sel = 1'b1;
      push(w(100));
      rwait(6);
      chk("R2 mode stays standard, flag", 32'(rflag_n), 32'd1);
      chk("R2 no fall-through", 32'(rd_data), 32'd0);
      pop("R4 read word after edge", w(100));
      rwait(4);
      chk("R4 data held without read", 32'(rd_data), 32'(w(100)));
      fwft_sel = 1'b0;

      push(w(200)); push(w(201)); push(w(202));
      chk("R9 three words below half", 32'(half_full), 32'd0);
      push(w(203));
      chk("R9 four words at half", 32'(half_full), 32'd1);
      push(w(204)); push(w(205)); push(w(206));
      chk("R10 seven words not full", 32'(wflag_n), 32'd1);
      push(w(207));
      chk("R10 eight words full", 32'(wflag_n), 32'd0);
      raw_write(w(900));
      raw_write(w(901));
      chk("R6 full flag after blocked writes", 32'(wflag_n), 32'd0);
      for (int i = 0; i < 8; i++) pop("R6 stored words intact", w(200 + i));
      chk("R6 blocked word absent", 32'(rflag_n), 32'd0);

      stream(1000, 150);

      // ---------------- fall-through mode ----------------
      do_reset(1'b1);
      chk("R5 reset output-ready", 32'(rflag_n), 32'd1);
      chk("R5 reset input-ready", 32'(wflag_n), 32'd0);
      raw_read();
      chk("R7 fwft read on empty", 32'(rd_data), 32'd0);

      push(w(300));
      rwait(6);
      chk("R5 word falls through", 32'(rflag_n), 32'd0);
      chk("R5 head word shown", 32'(rd_data), 32'(w(300)));
      chk("R1 upper slice bits", 32'(rd_data[15:8]), 32'(w(300) >> 8));
      chk("R1 lower slice bits", 32'(rd_data[7:0]), 32'(w(300) & 16'h00FF));
      pop("R5 head consumed", w(300));
      chk("R5 not ready after last read", 32'(rflag_n), 32'd1);

      for (int i = 0; i < 8; i++) push(w(400 + i));
      wwait(10);
      chk("R10 fwft room for ninth word", 32'(wflag_n), 32'd0);
      push(w(408));
      chk("R10 fwft full at nine", 32'(wflag_n), 32'd1);
      raw_write(w(902));
      for (int i = 0; i < 9; i++) pop("R6 fwft stored words intact", w(400 + i));
      rwait(4);
      chk("R6 fwft blocked word absent", 32'(rflag_n), 32'd1);

      stream(2000, 150);

      finish_run();
   end
endmodule